// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Status

This block is the receive half of an isochronous OUT endpoint inside a USB device controller. Bytes arriving from the serial interface engine are written into a 256-byte FIFO, and an end-of-packet strobe closes each packet. The block keeps a count of complete packets and an eight-bit status view, zero-extended to 32 bits, that the processor reads. The processor drains received data one byte per cycle through a pop port. Isochronous traffic cannot be retried. For that reason, a packet that begins when there is too little room for a packet of the programmed maximum size is dropped in full, and an overflow flag records the loss. A partial packet never enters the FIFO.

A receive finite-state machine sequences each packet through three states. RX_IDLE waits for a first byte. RX_STORE writes bytes into the FIFO. RX_DROP discards bytes. Four transitions are named:

- GO_STORE (RX_IDLE to RX_STORE): a first byte arrives and the free space is at least `max_pkt`.
- GO_DROP (RX_IDLE to RX_DROP): a first byte arrives and the free space is less than `max_pkt`.
- COMMIT (RX_STORE to RX_IDLE): end-of-packet is seen, and the packet is counted.
- ABANDON (RX_DROP to RX_IDLE): end-of-packet is seen, and nothing is recorded.

A delay-interrupt control bit selects when the interrupt fires. With the bit clear, the interrupt fires on packet completion. With the bit set, the interrupt also waits until the FIFO holds fewer than 32 bytes, which suits a DMA engine that drains the FIFO in bursts.

Top module: `iso_out_ep`

## Requirements
- R1: After reset, every bit of `reg_rdata` is 0 and `irq` is 0.
- R2: Status bit 0 (packet ready) reads 1 exactly when the FIFO holds at least one complete packet.
- R3: Status bit 1 (done) becomes 1 on the cycle after COMMIT. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged. If COMMIT and a write-1 to bit 1 fall in the same cycle, the bit stays 1.
- R4: Status bit 2 (overflow) becomes 1 on GO_DROP. The whole dropped packet leaves the FIFO contents and the packet count unchanged. Writing 1 to bit 2 clears it.
- R5: Status bit 3 (delay-interrupt control) reads back the value last written to it.
- R6: Status bits 31:8, 5 and 4 always read 0.
- R7: Status bit 6 (not empty) reads 1 whenever any byte is held in the FIFO, including bytes of a packet that is still arriving.
- R8: Status bit 7 (short) reads 1 when the oldest complete packet in the FIFO has fewer bytes than `max_pkt`.
- R9: Popping returns bytes in arrival order, with `pop_data` showing the head byte before the pop. A pop while bit 0 reads 0 has no effect.
- R10: The packet count falls when the last byte of a packet is popped. After the final stored packet is drained, bits 0 and 6 read 0.
- R11: When bit 3 is 0, `irq` equals bit 1. When bit 3 is 1, `irq` is high only while bit 1 is 1 and the FIFO holds fewer than 32 bytes.
- R12: An end-of-packet strobe received in RX_IDLE is ignored: no packet is counted and bit 1 is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte valid from the serial interface engine |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | End-of-packet strobe, driven on a cycle with no byte |
| max_pkt | input | 9 | Maximum packet size in bytes (1 to 256) |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 32 | Write data: bits 1 and 2 are write-1-to-clear, bit 3 is stored |
| reg_rdata | output | 32 | Status register read value |
| pop | input | 1 | Pop one byte from the FIFO head |
| pop_data | output | 8 | FIFO head byte |
| irq | output | 1 | Receive interrupt level |

## Verification
Two pairs of events can fall in the same cycle. In the first, the COMMIT edge and a processor write-1 to the done bit coincide. The bench drives `rx_eop` and `reg_wr` on the same cycle and expects the done bit to remain set. In the second, a pop of the last byte of the oldest packet coincides with packets still being counted. Here the bench follows the short and ready bits across the packet boundary while the scoreboard checks every popped byte against the order in which the bytes were sent.

// File: rtl/iso_ep_pkg.sv
package iso_ep_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_STORE = 2'd1,
        RX_DROP  = 2'd2
    } rx_state_e;

    localparam int READY_BIT = 0;
    localparam int DONE_BIT  = 1;
    localparam int OVF_BIT   = 2;
    localparam int DLY_BIT   = 3;
    localparam int NE_BIT    = 6;
    localparam int SHORT_BIT = 7;
endpackage

// File: rtl/ep_byte_fifo.sv
module ep_byte_fifo #(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          mark_en,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_last,
    output logic [CW-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] last_q;
    logic [AW-1:0]    wptr, rptr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr   <= '0;
            rptr   <= '0;
            count  <= '0;
            last_q <= '0;
        end else begin
            if (wr_en) begin
                last_q[wptr] <= 1'b0;
                wptr         <= wptr + 1'b1;
            end
            if (mark_en) last_q[AW'(wptr - 1'b1)] <= 1'b1;
            if (rd_en) rptr <= rptr + 1'b1;
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end

    assign rd_data = mem[rptr];
    assign rd_last = last_q[rptr];
endmodule

// File: rtl/ep_pkt_queue.sv
module ep_pkt_queue #(
    parameter int DEPTH = 256,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          push_short,
    input  logic          pop,
    output logic          head_short,
    output logic [CW-1:0] count
);
    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0] short_q;
    logic [AW-1:0]    wptr, rptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            short_q <= '0;
        end else begin
            if (push) begin
                short_q[wptr] <= push_short;
                wptr          <= wptr + 1'b1;
            end
            if (pop) rptr <= rptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head_short = short_q[rptr];
endmodule

// File: rtl/ep_rx_fsm.sv
module ep_rx_fsm
    import iso_ep_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_eop,
    input  logic          room_ok,
    input  logic          fifo_full,
    input  logic [CW-1:0] max_pkt,
    output logic          wr_en,
    output logic          commit,
    output logic          commit_short,
    output logic          drop_start,
    output rx_state_e     state
);
    rx_state_e     state_nx;
    logic [CW-1:0] len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     len <= '0;
        else if (wr_en) len <= (state == RX_IDLE) ? CW'(1) : len + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: begin
                if (rx_valid) state_nx = room_ok ? RX_STORE : RX_DROP;
            end
            RX_STORE: begin
                if (rx_eop) state_nx = RX_IDLE;
            end
            RX_DROP: begin
                if (rx_eop) state_nx = RX_IDLE;
            end
            default: state_nx = RX_IDLE;
        endcase
    end

    always_comb begin
        wr_en        = 1'b0;
        commit       = 1'b0;
        drop_start   = 1'b0;
        commit_short = (len < max_pkt);
        unique case (state)
            RX_IDLE: begin
                wr_en      = rx_valid && room_ok;
                drop_start = rx_valid && !room_ok;
            end
            RX_STORE: begin
                commit = rx_eop;
                wr_en  = rx_valid && !rx_eop && !fifo_full;
            end
            RX_DROP: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/iso_out_ep.sv
module iso_out_ep
    import iso_ep_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int DMA_LEVEL = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_data,
    input  logic                         rx_eop,
    input  logic [$clog2(DEPTH+1)-1:0]   max_pkt,
    input  logic                         reg_wr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic                         pop,
    output logic [7:0]                   pop_data,
    output logic                         irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] byte_cnt, pkt_cnt, free_cnt;
    logic          room_ok, fifo_full, wr_en, commit, commit_short, drop_start;
    logic          pop_ok, rd_last, head_short, ready;
    logic          done_q, ovf_q, dly_q;
    rx_state_e     rx_state;
    logic          unused_wdata;

    assign free_cnt  = CW'(DEPTH) - byte_cnt;
    assign room_ok   = free_cnt >= max_pkt;
    assign fifo_full = byte_cnt == CW'(DEPTH);
    assign ready     = pkt_cnt != '0;
    assign pop_ok    = pop && ready;

    ep_rx_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eop(rx_eop),
        .room_ok(room_ok), .fifo_full(fifo_full), .max_pkt(max_pkt),
        .wr_en(wr_en), .commit(commit), .commit_short(commit_short),
        .drop_start(drop_start), .state(rx_state)
    );

    ep_byte_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(rx_data),
        .mark_en(commit), .rd_en(pop_ok), .rd_data(pop_data),
        .rd_last(rd_last), .count(byte_cnt)
    );

    ep_pkt_queue #(.DEPTH(DEPTH), .CW(CW)) u_pktq (
        .clk(clk), .rst_n(rst_n), .push(commit), .push_short(commit_short),
        .pop(pop_ok && rd_last), .head_short(head_short), .count(pkt_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
            dly_q  <= 1'b0;
        end else begin
            if (commit)                               done_q <= 1'b1;
            else if (reg_wr && reg_wdata[DONE_BIT])   done_q <= 1'b0;
            if (drop_start)                           ovf_q  <= 1'b1;
            else if (reg_wr && reg_wdata[OVF_BIT])    ovf_q  <= 1'b0;
            if (reg_wr)                               dly_q  <= reg_wdata[DLY_BIT];
        end
    end

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[READY_BIT] = ready;
        reg_rdata[DONE_BIT]  = done_q;
        reg_rdata[OVF_BIT]   = ovf_q;
        reg_rdata[DLY_BIT]   = dly_q;
        reg_rdata[NE_BIT]    = byte_cnt != '0;
        reg_rdata[SHORT_BIT] = ready && head_short;
    end

    assign irq = done_q && (!dly_q || (byte_cnt < CW'(DMA_LEVEL)));

    assign unused_wdata = ^{reg_wdata[31:4], reg_wdata[0]};
endmodule

// File: rtl/iso_out_ep_chk.sv
module iso_out_ep_chk
    import iso_ep_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      rx_valid,
    input logic      rx_eop,
    input logic      reg_wr,
    input logic      wd_done,
    input logic      wd_dly,
    input logic [7:0] stat,
    input logic      irq,
    input rx_state_e rx_state,
    input logic      room_ok
);
    logic unused_bits;
    assign unused_bits = ^stat[5:4];

    a_r3_done_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == RX_STORE && rx_eop) |=> stat[DONE_BIT]);

    a_r3_done_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wd_done && !(rx_state == RX_STORE && rx_eop)) |=> !stat[DONE_BIT]);

    a_r4_ovf_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == RX_IDLE && rx_valid && !room_ok) |=> stat[OVF_BIT]);

    a_r5_dly_readback: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (stat[DLY_BIT] == $past(wd_dly)));

    a_r11_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat[DONE_BIT]);

    a_r7_ready_implies_ne: assert property (@(posedge clk) disable iff (!rst_n)
        stat[READY_BIT] |-> stat[NE_BIT]);

    a_r8_short_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
        stat[SHORT_BIT] |-> stat[READY_BIT]);
endmodule

bind iso_out_ep iso_out_ep_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eop(rx_eop),
    .reg_wr(reg_wr), .wd_done(reg_wdata[1]), .wd_dly(reg_wdata[3]),
    .stat(reg_rdata[7:0]), .irq(irq), .rx_state(rx_state), .room_ok(room_ok)
);

// File: tb/tb_iso_out_ep.sv
`timescale 1ns/1ps
module tb_iso_out_ep;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_eop = 1'b0;
    logic [8:0]  max_pkt = 9'd16;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pop = 1'b0;
    logic [7:0]  pop_data;
    logic        irq;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    iso_out_ep dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eop(rx_eop), .max_pkt(max_pkt), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pop(pop),
        .pop_data(pop_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic send_bytes(input int n, input int base, input bit keep);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(base + i);
            if (keep) exp_q.push_back(8'(base + i));
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic end_pkt();
        rx_eop = 1'b1;
        @(negedge clk);
        rx_eop = 1'b0;
    endtask

    task automatic send_pkt(input int n, input int base, input bit keep);
        send_bytes(n, base, keep);
        end_pkt();
    endtask

    // monitor side of the scoreboard: one popped byte against the queue head
    task automatic pop_one();
        logic [7:0] e;
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'hxx;
        check("R9 pop order", {24'b0, pop_data}, {24'b0, e});
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic drain(output int n);
        n = 0;
        while (reg_rdata[0] === 1'b1) begin
            pop_one();
            n++;
        end
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", reg_rdata, 32'h0);
        check("R1 reset irq", {31'b0, irq}, 32'h0);

        // R5 delay bit read back, R6 reserved bits
        reg_write(32'hFFFF_FFF9);
        check("R5 delay bit set", {31'b0, reg_rdata[3]}, 32'h1);
        check("R6 reserved bits", {reg_rdata[31:8], 2'b0, reg_rdata[5:4]}, 32'h0);
        reg_write(32'h0);
        check("R5 delay bit cleared", {31'b0, reg_rdata[3]}, 32'h0);

        // R7, R2, R9: partial packet visible as not-empty, not ready, pop ignored
        max_pkt = 9'd16;
        send_bytes(5, 8'h10, 1'b1);
        check("R7 not empty mid packet", {31'b0, reg_rdata[6]}, 32'h1);
        check("R2 not ready mid packet", {31'b0, reg_rdata[0]}, 32'h0);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        check("R9 pop ignored head", {24'b0, pop_data}, 32'h10);
        end_pkt();
        check("R2 ready after commit", {31'b0, reg_rdata[0]}, 32'h1);
        check("R3 done after commit", {31'b0, reg_rdata[1]}, 32'h1);
        check("R8 short packet", {31'b0, reg_rdata[7]}, 32'h1);
        check("R11 irq immediate", {31'b0, irq}, 32'h1);
        reg_write(32'h0);
        check("R3 write 0 keeps done", {31'b0, reg_rdata[1]}, 32'h1);
        reg_write(32'h2);
        check("R3 write 1 clears done", {31'b0, reg_rdata[1]}, 32'h0);
        check("R11 irq follows done", {31'b0, irq}, 32'h0);

        // R8 short follows the oldest packet across a boundary
        send_pkt(16, 8'h40, 1'b1);
        check("R8 oldest still short", {31'b0, reg_rdata[7]}, 32'h1);
        for (int i = 0; i < 5; i++) pop_one();
        check("R8 full-size head not short", {31'b0, reg_rdata[7]}, 32'h0);
        check("R10 one packet left", {31'b0, reg_rdata[0]}, 32'h1);
        drain(n);
        check("R10 drained ready", {31'b0, reg_rdata[0]}, 32'h0);
        check("R10 drained empty", {31'b0, reg_rdata[6]}, 32'h0);

        // R11 delayed interrupt with threshold
        reg_write(32'h0000_000A);
        send_pkt(16, 8'h60, 1'b1);
        send_pkt(16, 8'h70, 1'b1);
        send_pkt(16, 8'h80, 1'b1);
        check("R11 delayed irq held at 48 bytes", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 16; i++) pop_one();
        check("R11 delayed irq held at 32 bytes", {31'b0, irq}, 32'h0);
        pop_one();
        check("R11 delayed irq at 31 bytes", {31'b0, irq}, 32'h1);
        drain(n);
        check("R10 drain count", n, 31);
        reg_write(32'h6);

        // R4 overflow drops a whole packet
        max_pkt = 9'd64;
        send_pkt(50, 8'h00, 1'b1);
        send_pkt(50, 8'h32, 1'b1);
        send_pkt(50, 8'h64, 1'b1);
        send_pkt(50, 8'h96, 1'b1);
        check("R4 no overflow yet", {31'b0, reg_rdata[2]}, 32'h0);
        send_pkt(10, 8'hE0, 1'b0);
        check("R4 overflow set", {31'b0, reg_rdata[2]}, 32'h1);
        check("R8 short with larger max", {31'b0, reg_rdata[7]}, 32'h1);
        drain(n);
        check("R4 dropped bytes absent", n, 200);
        check("R4 empty after drain", {31'b0, reg_rdata[6]}, 32'h0);
        reg_write(32'h4);
        check("R4 overflow cleared", {31'b0, reg_rdata[2]}, 32'h0);
        send_pkt(3, 8'hC0, 1'b1);
        check("R4 accepting again", {31'b0, reg_rdata[0]}, 32'h1);
        drain(n);
        reg_write(32'h6);

        // R3 commit and write-1 clear in the same cycle
        send_bytes(4, 8'hA0, 1'b1);
        rx_eop = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h2;
        @(negedge clk);
        rx_eop = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        check("R3 set wins over clear", {31'b0, reg_rdata[1]}, 32'h1);
        drain(n);
        reg_write(32'h2);

        // R12 end-of-packet while idle
        end_pkt();
        check("R12 idle eop no packet", {31'b0, reg_rdata[0]}, 32'h0);
        check("R12 idle eop no done", {31'b0, reg_rdata[1]}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule